// File: doc/BRIEF.md
# Output Compare Timer with Coherent Counter Reads

This block is a byte-wide timer peripheral on a simple synchronous CPU bus. A 16-bit free-running up-counter advances on ticks from a prescaler that divides the system clock by 1, 4, 8 or 16. Software cannot write the counter. Software reads it as two bytes: the high byte first, then the low byte. The read of the high byte captures the low byte in a holding register, so the pair always describes one counter value.

Four output-compare channels each hold a 16-bit compare value and drive one output pin. A match occurs on a prescaler tick when the counter equals a channel's compare value. A two-bit action code per channel then decides what the pin does: stay untouched, toggle, go low or go high. The last channel is blocked from acting on its pin while an external inhibit input is high. In that state the same timer resource serves a capture function elsewhere in the chip.

Top module: `ocmp_timer`

## Requirements
- R1: After reset, every output pin is 0, the action register, the prescale register and all compare registers read 0, and the counter high byte reads 0.
- R2: The counter is 16 bits wide. It adds 1 on every prescaler tick, wraps from 0xFFFF to 0x0000, and bus writes to offsets 0x0E and 0x0F do not change it.
- R3: A read of offset 0x0E returns the counter high byte and copies the low byte into a holding register. If the next bus access reads offset 0x0F, it returns the held byte, so the pair equals the counter value at the high-byte read.
- R4: A read of offset 0x0F whose previous bus access was not a read of 0x0E returns the live counter low byte.
- R5: The prescale register at offset 0x24 uses bits [1:0] to select the tick rate: 00 every clock, 01 every 4, 10 every 8, 11 every 16. Writing it restarts the division phase.
- R6: The action register at offset 0x20 holds a 2-bit code for each channel, channel 0 in bits [7:6] down to channel 3 in bits [1:0]. Code 00 leaves that channel's pin unchanged on a match.
- R7: On a match, code 01 inverts the pin, code 10 drives it to 0 and code 11 drives it to 1. The new level is visible after the clock edge at which the counter holds the compare value during a tick. Between matches the pin holds its level.
- R8: Channel n has a compare register with its high byte at offset 0x16+2n and its low byte at 0x17+2n. Both bytes are writable and read back.
- R9: While the inhibit input is 1, channel 3 leaves its pin unchanged on a match. Channels 0 to 2 are not affected.
- R10: Read data is registered. It appears after the clock edge that samples the read strobe and holds until the next read. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rdata | output | 8 | Registered read data |
| last_ch_inhibit | input | 1 | Blocks channel 3 from acting on its pin |
| oc_pin | output | 4 | Compare output pins, bit n for channel n |

## Verification
Every read result is due one edge after its strobe is sampled. The value it carries is the counter as held at that same edge. With divide-by-1, the bench therefore predicts each counter read from an anchor read and the number of edges in between, and it samples at the following falling edge. A pin action is due after the edge at which the counter equals the compare value. One toggle is checked on the falling edges just before and just after that edge, and the other actions are checked well after their match. Prescaler rates are measured over 320-clock windows, which span a whole number of ticks for any phase at every divisor.

// File: rtl/ocm_pkg.sv
package ocm_pkg;

  typedef enum logic [1:0] {
    OC_KEEP = 2'b00,
    OC_FLIP = 2'b01,
    OC_LOW  = 2'b10,
    OC_HIGH = 2'b11
  } oc_act_e;

  localparam int A_CNT_HI   = 8'h0E;
  localparam int A_CNT_LO   = 8'h0F;
  localparam int A_CMP_BASE = 8'h16;
  localparam int A_CTRL     = 8'h20;
  localparam int A_DIV      = 8'h24;

endpackage

// File: rtl/ocm_prescaler.sv
module ocm_prescaler #(
  parameter int PRE_W = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] div_sel,
  input  logic       restart,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q, pre_d;
  logic [PRE_W-1:0] limit;

  // divide ratio 1, 4, 8, 16 -> terminal count 0, 3, 7, 15
  always_comb begin
    case (div_sel)
      2'b00:   limit = '0;
      2'b01:   limit = PRE_W'(3);
      2'b10:   limit = PRE_W'(7);
      default: limit = PRE_W'(15);
    endcase
  end

  assign tick = (pre_q == limit);

  always_comb begin
    pre_d = pre_q;
    if (restart) begin
      pre_d = '0;
    end else if (tick) begin
      pre_d = '0;
    end else begin
      pre_d = pre_q + PRE_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end

endmodule

// File: rtl/ocm_counter.sv
module ocm_counter #(
  parameter int DATA_W = 8,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              hi_rd,
  input  logic              bus_acc,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [DATA_W-1:0] lo_view
);

  logic [CNT_W-1:0]  cnt_d;
  logic [DATA_W-1:0] hold_q, hold_d;
  logic              coh_q, coh_d;

  always_comb begin
    cnt_d = cnt_q;
    if (tick) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  // capture the low byte with the high-byte read; the flag lives for one access
  always_comb begin
    hold_d = hold_q;
    coh_d  = coh_q;
    if (hi_rd) begin
      hold_d = cnt_q[DATA_W-1:0];
    end
    if (bus_acc) begin
      coh_d = hi_rd;
    end
  end

  assign lo_view = coh_q ? hold_q : cnt_q[DATA_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      hold_q <= '0;
      coh_q  <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      hold_q <= hold_d;
      coh_q  <= coh_d;
    end
  end

endmodule

// File: rtl/ocm_channel.sv
module ocm_channel
  import ocm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic [1:0]       act,
  input  logic             enable,
  output logic             pin_q
);

  logic    pin_d;
  logic    hit;
  oc_act_e code;

  assign code = oc_act_e'(act);
  assign hit  = tick && enable && (cnt == cmp);

  always_comb begin
    pin_d = pin_q;
    if (hit) begin
      case (code)
        OC_FLIP: pin_d = ~pin_q;
        OC_LOW:  pin_d = 1'b0;
        OC_HIGH: pin_d = 1'b1;
        default: pin_d = pin_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pin_q <= 1'b0;
    end else begin
      pin_q <= pin_d;
    end
  end

endmodule

// File: rtl/ocm_regs.sv
module ocm_regs
  import ocm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NCH    = 4,
  parameter int CNT_W  = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic [ADDR_W-1:0]          addr,
  input  logic [DATA_W-1:0]          wdata,
  input  logic                       rd_en,
  input  logic                       wr_en,
  input  logic [DATA_W-1:0]          cnt_hi,
  input  logic [DATA_W-1:0]          cnt_lo_view,
  output logic                       hi_rd,
  output logic                       bus_acc,
  output logic [DATA_W-1:0]          rdata,
  output logic [NCH-1:0][1:0]        act,
  output logic [NCH-1:0][CNT_W-1:0]  cmp,
  output logic [1:0]                 div_sel,
  output logic                       div_restart
);

  localparam int CTRL_W = 2 * NCH;

  logic [CTRL_W-1:0]             ctrl_q, ctrl_d;
  logic [1:0]                    div_q, div_d;
  logic [NCH-1:0][CNT_W-1:0]     cmp_q, cmp_d;
  logic [DATA_W-1:0]             rdata_q, rdata_d;
  logic [DATA_W-1:0]             rd_val;

  assign bus_acc = rd_en || wr_en;
  assign hi_rd   = rd_en && (addr == ADDR_W'(A_CNT_HI));

  // write side
  always_comb begin
    ctrl_d      = ctrl_q;
    div_d       = div_q;
    cmp_d       = cmp_q;
    div_restart = 1'b0;
    if (wr_en) begin
      if (addr == ADDR_W'(A_CTRL)) begin
        ctrl_d = wdata[CTRL_W-1:0];
      end
      if (addr == ADDR_W'(A_DIV)) begin
        div_d       = wdata[1:0];
        div_restart = 1'b1;
      end
      for (int i = 0; i < NCH; i++) begin
        if (addr == ADDR_W'(A_CMP_BASE + 2 * i)) begin
          cmp_d[i][DATA_W +: DATA_W] = wdata;
        end
        if (addr == ADDR_W'(A_CMP_BASE + 2 * i + 1)) begin
          cmp_d[i][0 +: DATA_W] = wdata;
        end
      end
    end
  end

  // read side
  always_comb begin
    rd_val = '0;
    if (addr == ADDR_W'(A_CNT_HI)) rd_val = cnt_hi;
    if (addr == ADDR_W'(A_CNT_LO)) rd_val = cnt_lo_view;
    if (addr == ADDR_W'(A_CTRL))   rd_val = DATA_W'(ctrl_q);
    if (addr == ADDR_W'(A_DIV))    rd_val = DATA_W'(div_q);
    for (int i = 0; i < NCH; i++) begin
      if (addr == ADDR_W'(A_CMP_BASE + 2 * i)) begin
        rd_val = cmp_q[i][DATA_W +: DATA_W];
      end
      if (addr == ADDR_W'(A_CMP_BASE + 2 * i + 1)) begin
        rd_val = cmp_q[i][0 +: DATA_W];
      end
    end
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      rdata_d = rd_val;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= '0;
      div_q   <= '0;
      cmp_q   <= '0;
      rdata_q <= '0;
    end else begin
      ctrl_q  <= ctrl_d;
      div_q   <= div_d;
      cmp_q   <= cmp_d;
      rdata_q <= rdata_d;
    end
  end

  // channel 0 takes the top pair of bits
  for (genvar gi = 0; gi < NCH; gi++) begin : g_act
    assign act[gi] = ctrl_q[2 * (NCH - 1 - gi) +: 2];
  end

  assign cmp     = cmp_q;
  assign div_sel = div_q;
  assign rdata   = rdata_q;

endmodule

// File: rtl/ocmp_timer.sv
module ocmp_timer
  import ocm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NCH    = 4,
  parameter int PRE_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_rd,
  input  logic              bus_wr,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              last_ch_inhibit,
  output logic [NCH-1:0]    oc_pin
);

  localparam int CNT_W = 2 * DATA_W;

  logic [1:0]                rst_sync_q;
  logic                      rst_sync_n;
  logic                      tick;
  logic [CNT_W-1:0]          cnt_q;
  logic [DATA_W-1:0]         lo_view;
  logic                      hi_rd;
  logic                      bus_acc;
  logic [NCH-1:0][1:0]       act;
  logic [NCH-1:0][CNT_W-1:0] cmp;
  logic [1:0]                div_sel;
  logic                      div_restart;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= '0;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_sync_n = rst_sync_q[1];

  ocm_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .div_sel (div_sel),
    .restart (div_restart),
    .tick    (tick)
  );

  ocm_counter #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .tick    (tick),
    .hi_rd   (hi_rd),
    .bus_acc (bus_acc),
    .cnt_q   (cnt_q),
    .lo_view (lo_view)
  );

  ocm_regs #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .NCH    (NCH),
    .CNT_W  (CNT_W)
  ) u_regs (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .addr        (bus_addr),
    .wdata       (bus_wdata),
    .rd_en       (bus_rd),
    .wr_en       (bus_wr),
    .cnt_hi      (cnt_q[CNT_W-1 -: DATA_W]),
    .cnt_lo_view (lo_view),
    .hi_rd       (hi_rd),
    .bus_acc     (bus_acc),
    .rdata       (bus_rdata),
    .act         (act),
    .cmp         (cmp),
    .div_sel     (div_sel),
    .div_restart (div_restart)
  );

  for (genvar gc = 0; gc < NCH; gc++) begin : g_ch
    logic ch_en;
    if (gc == NCH - 1) begin : g_gated
      assign ch_en = ~last_ch_inhibit;
    end else begin : g_free
      assign ch_en = 1'b1;
    end

    ocm_channel #(.CNT_W(CNT_W)) u_ch (
      .clk    (clk),
      .rst_n  (rst_sync_n),
      .tick   (tick),
      .cnt    (cnt_q),
      .cmp    (cmp[gc]),
      .act    (act[gc]),
      .enable (ch_en),
      .pin_q  (oc_pin[gc])
    );
  end

endmodule

// File: rtl/ocm_checker.sv
module ocm_checker #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter int NCH    = 4,
  parameter int CNT_W  = 16
) (
  input logic                      clk,
  input logic                      rst_n,
  input logic                      tick,
  input logic [CNT_W-1:0]          cnt,
  input logic [ADDR_W-1:0]         addr,
  input logic                      rd_en,
  input logic [DATA_W-1:0]         rdata,
  input logic [NCH-1:0][1:0]       act,
  input logic [NCH-1:0][CNT_W-1:0] cmp,
  input logic                      inhibit,
  input logic [NCH-1:0]            pin
);

  a_r2_step_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> cnt == $past(cnt) + CNT_W'(1));

  a_r2_hold_off_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> cnt == $past(cnt));

  a_r3_coherent_low: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == ADDR_W'(8'h0F) && $past(rd_en && addr == ADDR_W'(8'h0E)))
      |=> rdata == $past(cnt[DATA_W-1:0], 2));

  a_r9_inhibit_holds: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> pin[NCH-1] == $past(pin[NCH-1]));

  for (genvar gi = 0; gi < NCH; gi++) begin : g_chk
    logic en;
    assign en = (gi != NCH - 1) || !inhibit;

    a_r6_keep_code: assert property (@(posedge clk) disable iff (!rst_n)
      act[gi] == 2'b00 |=> pin[gi] == $past(pin[gi]));

    a_r7_set_code: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && en && cnt == cmp[gi] && act[gi] == 2'b11) |=> pin[gi]);

    a_r7_clear_code: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && en && cnt == cmp[gi] && act[gi] == 2'b10) |=> !pin[gi]);

    a_r7_toggle_code: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && en && cnt == cmp[gi] && act[gi] == 2'b01) |=> pin[gi] != $past(pin[gi]));

    a_r7_hold_no_match: assert property (@(posedge clk) disable iff (!rst_n)
      !(tick && cnt == cmp[gi]) |=> pin[gi] == $past(pin[gi]));
  end

endmodule

bind ocmp_timer ocm_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .NCH    (NCH),
  .CNT_W  (CNT_W)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_sync_n),
  .tick    (tick),
  .cnt     (cnt_q),
  .addr    (bus_addr),
  .rd_en   (bus_rd),
  .rdata   (bus_rdata),
  .act     (act),
  .cmp     (cmp),
  .inhibit (last_ch_inhibit),
  .pin     (oc_pin)
);

// File: tb/test_ocmp_timer.sv
module test_ocmp_timer;

  logic       clk;
  logic       rst_n;
  logic [7:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_rd;
  logic       bus_wr;
  logic [7:0] bus_rdata;
  logic       last_ch_inhibit;
  logic [3:0] oc_pin;

  int unsigned cyc = 0;
  int          n_chk = 0;
  int          n_fail = 0;
  logic [15:0] v0;
  int          e0;
  logic [3:0]  exp_pins;
  bit          done = 0;

  ocmp_timer i_ocmp_timer (
    .clk             (clk),
    .rst_n           (rst_n),
    .bus_addr        (bus_addr),
    .bus_wdata       (bus_wdata),
    .bus_rd          (bus_rd),
    .bus_wr          (bus_wr),
    .bus_rdata       (bus_rdata),
    .last_ch_inhibit (last_ch_inhibit),
    .oc_pin          (oc_pin)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp,
                       input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  endtask

  // called at a falling edge; the access is sampled at the next rising edge
  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    bus_addr = a;
    bus_rd   = 1'b1;
    @(negedge clk);
    bus_rd   = 1'b0;
    d        = bus_rdata;
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    bus_addr  = a;
    bus_wdata = d;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic rd_pair(output logic [15:0] v, output int e);
    logic [7:0] h, l;
    rd(8'h0E, h);
    e = cyc;
    rd(8'h0F, l);
    v = {h, l};
  endtask

  function automatic logic [15:0] pred(input int e);
    return 16'(int'(v0) + (e - e0));
  endfunction

  task automatic anchor();
    rd_pair(v0, e0);
  endtask

  task automatic set_cmp(input int ch, input logic [15:0] t);
    wr(8'(8'h16 + 2 * ch), t[15:8]);
    wr(8'(8'h17 + 2 * ch), t[7:0]);
  endtask

  task automatic t_reset();
    logic [7:0] d;
    check("R1", 16'(oc_pin), 16'h0, "pins after reset");
    rd(8'h0E, d); check("R1", 16'(d), 16'h0, "counter high after reset");
    rd(8'h20, d); check("R1", 16'(d), 16'h0, "action reg after reset");
    rd(8'h24, d); check("R1", 16'(d), 16'h0, "prescale reg after reset");
    rd(8'h1C, d); check("R1", 16'(d), 16'h0, "compare high after reset");
    rd(8'h30, d); check("R10", 16'(d), 16'h0, "unmapped offset");
  endtask

  task automatic t_cmp_readback();
    logic [7:0] d;
    set_cmp(1, 16'hC3A5);
    rd(8'h18, d); check("R8", 16'(d), 16'h00C3, "channel 1 compare high");
    @(negedge clk);
    check("R10", 16'(bus_rdata), 16'h00C3, "read data held between reads");
    rd(8'h19, d); check("R8", 16'(d), 16'h00A5, "channel 1 compare low");
  endtask

  task automatic t_no_write();
    logic [15:0] v;
    int e;
    wr(8'h0E, 8'hAA);
    wr(8'h0F, 8'h55);
    rd_pair(v, e);
    check("R2", v, pred(e), "counter after write attempt");
  endtask

  task automatic t_rollover();
    logic [15:0] v;
    logic [7:0]  d;
    int e;
    while (pred(cyc + 1) % 256 != 255) @(negedge clk);
    rd_pair(v, e);
    check("R3", v, pred(e), "coherent pair across low-byte wrap");
    check("R3", 16'(v[7:0]), 16'h00FF, "held low byte");
    rd(8'h0F, d);
    check("R4", 16'(d), 16'(pred(cyc) % 256), "live low after held read");
    rd(8'h0E, d);
    wr(8'h30, 8'h00);
    rd(8'h0F, d);
    check("R4", 16'(d), 16'(pred(cyc) % 256), "live low after intervening write");
  endtask

  task automatic t_wrap16();
    logic [15:0] v;
    int e;
    anchor();
    while (pred(cyc + 1) != 16'hFFFF) @(negedge clk);
    rd_pair(v, e);
    check("R2", v, 16'hFFFF, "counter at top value");
    rd_pair(v, e);
    check("R2", v, 16'h0001, "counter wrapped to zero");
  endtask

  task automatic t_action(input int ch, input logic [1:0] code, input string req);
    logic [15:0] t;
    wr(8'h20, 8'(code) << (2 * (3 - ch)));
    t = pred(cyc) + 16'd40;
    set_cmp(ch, t);
    repeat (60) @(negedge clk);
    case (code)
      2'b01: exp_pins[ch] = ~exp_pins[ch];
      2'b10: exp_pins[ch] = 1'b0;
      2'b11: exp_pins[ch] = 1'b1;
      default: exp_pins[ch] = exp_pins[ch];
    endcase
    check(req, 16'(oc_pin), 16'(exp_pins), $sformatf("pins ch%0d code %b", ch, code));
  endtask

  task automatic t_all_actions();
    for (int ch = 0; ch < 4; ch++) begin
      t_action(ch, 2'b11, "R7");
      t_action(ch, 2'b00, "R6");
      t_action(ch, 2'b10, "R7");
      t_action(ch, 2'b01, "R7");
      t_action(ch, 2'b01, "R7");
    end
  endtask

  task automatic t_exact_edge();
    logic [15:0] t;
    int em;
    wr(8'h20, 8'h40);
    t = pred(cyc) + 16'd30;
    set_cmp(0, t);
    em = cyc + int'(16'(t - pred(cyc)));
    while (cyc < em - 1) @(negedge clk);
    check("R7", 16'(oc_pin), 16'(exp_pins), "pins one edge before match");
    @(negedge clk);
    exp_pins[0] = ~exp_pins[0];
    check("R7", 16'(oc_pin), 16'(exp_pins), "pins right after match edge");
  endtask

  task automatic t_inhibit();
    logic [15:0] t;
    last_ch_inhibit = 1'b1;
    wr(8'h20, 8'hFF);
    t = pred(cyc) + 16'd40;
    set_cmp(0, t);
    set_cmp(3, t);
    repeat (60) @(negedge clk);
    exp_pins[0] = 1'b1;
    check("R9", 16'(oc_pin), 16'(exp_pins), "channel 3 blocked, channel 0 free");
    last_ch_inhibit = 1'b0;
    t = pred(cyc) + 16'd40;
    set_cmp(3, t);
    repeat (60) @(negedge clk);
    exp_pins[3] = 1'b1;
    check("R9", 16'(oc_pin), 16'(exp_pins), "channel 3 acts after release");
    wr(8'h20, 8'h00);
  endtask

  task automatic t_prescale();
    logic [15:0] va, vb;
    int ea, eb;
    for (int code = 3; code >= 0; code--) begin
      wr(8'h24, 8'(code));
      rd_pair(va, ea);
      while (cyc < ea + 319) @(negedge clk);
      rd_pair(vb, eb);
      check("R5", vb - va, 16'(320 / (code == 0 ? 1 : (1 << (code + 1)))),
            $sformatf("ticks in 320 clocks, select %0d", code));
    end
    anchor();
  endtask

  initial begin
    rst_n = 1'b0;
    bus_addr = '0;
    bus_wdata = '0;
    bus_rd = 1'b0;
    bus_wr = 1'b0;
    last_ch_inhibit = 1'b0;
    exp_pins = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_cmp_readback();
    anchor();
    t_no_write();
    t_rollover();
    t_wrap16();
    t_all_actions();
    t_exact_edge();
    t_inhibit();
    t_prescale();
    done = 1;
    summary();
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

endmodule